// File: doc/BRIEF.md
# Branch Trace Run Recorder

The recorder sits beside a processor's retirement stage and keeps a compact picture of where the program went. It does not keep every address. It splits the retired stream into runs of straight-line code, where each address is the previous one plus 4. For each run it stores only the first and the last address, as a pair of words in a 64-entry trace memory. An outside agent decodes branches and resolves their outcome. It presents each retired instruction with a taken flag and, when that flag is set, the target address.

A start pulse arms the recorder and clears its previous contents. A stop pulse closes the open run and returns the block to idle. While the block is recording, a 32-bit counter tallies retired instructions. The tally can be rebuilt from the stored pairs as the sum over runs of (last − first)/4 + 1. Software or a debug agent reads the trace words through an index port, with one cycle of read latency.

When the trace memory fills, the block drops further entries and raises a sticky overflow flag. The retire counter keeps running after overflow.

Top module: `run_trace_recorder`

## Requirements
- R1: A start pulse while idle clears the entry count, the overflow flag and the retire counter, and begins recording. The first retire after that writes its own address as entry 0.
- R2: While recording, a retire whose address equals the expected address writes no entry. The expected address is the previous address + 4, or the branch target after a taken retire. A retire with the taken flag low counts as not taken.
- R3: A retire flagged as taken appends two entries in this order: the retiring instruction's own address, which ends the run, and then the target address, which starts the next run.
- R4: A retire whose address breaks sequential flow, when the previous retire was not a taken branch, appends two entries in this order: the previous retired address and then the current address.
- R5: The first retire after a taken branch may carry an address different from the recorded target. In that case the stored target entry is overwritten with the actual address, and the entry count does not change.
- R6: A stop pulse while recording ends recording. If a run holds retired instructions, stop appends the last retired address. If the open run is only a recorded target with nothing retired in it, stop removes that target entry. A retire in the same cycle as stop is ignored.
- R7: The trace memory holds 64 entries. Entries beyond that are dropped in order. The entry count stays at 64, and the overflow flag is set and stays set until the next start.
- R8: The retire counter increments by one for each retire strobe while recording, and strobes while idle are ignored. With no overflow, the counter equals the sum over the stored pairs of (last − first)/4 + 1.
- R9: The read data port shows trace entry number `rdIdx` one clock after the index is presented.
- R10: A start pulse while recording and a stop pulse while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Arm the recorder and clear previous trace |
| stopReq | input | 1 | Close the open run and return to idle |
| retireVld | input | 1 | One instruction retires this cycle |
| retireAddr | input | 32 | Address of the retiring instruction |
| takenVld | input | 1 | The retiring instruction is a branch that was taken |
| takenTarget | input | 32 | Target address of the taken branch |
| rdIdx | input | 6 | Trace entry index to read |
| rdData | output | 32 | Trace entry contents, one cycle after rdIdx |
| entryCount | output | 7 | Number of valid trace entries |
| overflow | output | 1 | Sticky: an entry was dropped for lack of space |
| retireCount | output | 32 | Instructions retired since start |
| recording | output | 1 | High while the recorder is armed |

## Verification
The bench targets a taken branch whose successor does not land on the target. A design that appends there instead of patching leaves a zero-length run, and the tally no longer matches the counter. It also stops right after a taken branch, where an unconsumed target must be withdrawn, and it stops in the same cycle as a retire, which would otherwise count an extra instruction. It drives the memory past 64 entries with a burst of jumps. A design that wraps the write pointer overwrites entry 0, and one that freezes the counter reports too few retires. Random runs mix sequential steps, jumps and taken branches, and every stored word is compared against a model built from the requirements.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

  typedef enum logic {ST_IDLE, ST_REC} rtrState_e;

  // Per-cycle commands from the control to the datapath.
  typedef struct packed {
    logic clearAll;       // wipe counters and trace state
    logic countRetire;    // bump the retire counter
    logic trackRetire;    // remember this address and the next expected one
    logic openAtCur;      // append current address as a run start
    logic closeAtLast;    // append previous address as a run end
    logic fixFreshStart;  // overwrite the pending target entry with current address
    logic branchPair;     // append current address and the taken target
    logic dropFresh;      // withdraw the pending target entry
  } rtrStrobes_t;

  localparam int SLOTS = 4;  // most entries a single cycle can append

endpackage

// File: rtl/rtr_ctrl.sv
module rtr_ctrl
  import rtr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        stopReq,
  input  logic        retireVld,
  input  logic        takenVld,
  input  logic        seqMatch,
  output rtrStrobes_t strb,
  output logic        recording
);

  rtrState_e state, stateNxt;
  logic runOpen, runNxt;
  logic fresh, freshNxt;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    runNxt   = runOpen;
    freshNxt = fresh;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.clearAll = 1'b1;
          stateNxt      = ST_REC;
          runNxt        = 1'b0;
          freshNxt      = 1'b0;
        end
      end
      ST_REC: begin
        if (stopReq) begin
          if (runOpen) begin
            if (fresh) strb.dropFresh   = 1'b1;
            else       strb.closeAtLast = 1'b1;
          end
          stateNxt = ST_IDLE;
          runNxt   = 1'b0;
          freshNxt = 1'b0;
        end else if (retireVld) begin
          strb.countRetire = 1'b1;
          strb.trackRetire = 1'b1;
          if (!runOpen) begin
            strb.openAtCur = 1'b1;
          end else if (!seqMatch) begin
            if (fresh) begin
              strb.fixFreshStart = 1'b1;
            end else begin
              strb.closeAtLast = 1'b1;
              strb.openAtCur   = 1'b1;
            end
          end
          strb.branchPair = takenVld;
          runNxt          = 1'b1;
          freshNxt        = takenVld;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      runOpen <= 1'b0;
      fresh   <= 1'b0;
    end else begin
      state   <= stateNxt;
      runOpen <= runNxt;
      fresh   <= freshNxt;
    end
  end

  assign recording = (state == ST_REC);

  // R1: first retire after start opens a run at its own address
  a_r1_first_opens: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REC && !stopReq && retireVld && !runOpen) |-> strb.openAtCur);

  // R2: a matching, not-taken retire appends nothing
  a_r2_seq_silent: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REC && !stopReq && retireVld && runOpen && seqMatch && !takenVld)
      |-> !(strb.openAtCur || strb.closeAtLast || strb.branchPair || strb.fixFreshStart));

  // R6: stop always returns to idle
  a_r6_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REC && stopReq) |=> (state == ST_IDLE));

  // R10: a start pulse while recording does not restart
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REC && !stopReq) |=> (state == ST_REC && !$rose(strb.clearAll)));

  // R5: patching and opening never coincide
  a_r5_fix_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    strb.fixFreshStart |-> !(strb.openAtCur || strb.closeAtLast));

endmodule

// File: rtl/rtr_datapath.sv
module rtr_datapath
  import rtr_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 32,
  parameter int CNTW  = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  rtrStrobes_t     strb,
  input  logic [AW-1:0]   retireAddr,
  input  logic [AW-1:0]   takenTarget,
  input  logic [IW-1:0]   rdIdx,
  output logic            seqMatch,
  output logic [AW-1:0]   rdData,
  output logic [CW-1:0]   entryCount,
  output logic            overflow,
  output logic [CNTW-1:0] retireCount
);

  logic [AW-1:0] mem [DEPTH];
  logic [AW-1:0] lastAddr, expectAddr;
  logic          freshStored;

  logic [AW-1:0] slotWord [SLOTS];
  logic [CW-1:0] slotNum, space, nFit;
  logic          spill;

  assign seqMatch = (retireAddr == expectAddr);

  // Pack this cycle's appended words in order: old run end, new run start,
  // then the branch pair (its own address, then its target).
  always_comb begin
    slotNum = '0;
    for (int k = 0; k < SLOTS; k++) slotWord[k] = '0;
    if (strb.closeAtLast) begin
      slotWord[slotNum[1:0]] = lastAddr;
      slotNum = slotNum + 1'b1;
    end
    if (strb.openAtCur) begin
      slotWord[slotNum[1:0]] = retireAddr;
      slotNum = slotNum + 1'b1;
    end
    if (strb.branchPair) begin
      slotWord[slotNum[1:0]] = retireAddr;
      slotNum = slotNum + 1'b1;
      slotWord[slotNum[1:0]] = takenTarget;
      slotNum = slotNum + 1'b1;
    end
    space = CW'(DEPTH) - entryCount;
    spill = (slotNum > space);
    nFit  = spill ? space : slotNum;
  end

  // Trace storage, no reset
  always_ff @(posedge clk) begin
    for (int k = 0; k < SLOTS; k++) begin
      if (CW'(k) < nFit) mem[IW'(entryCount + CW'(k))] <= slotWord[k];
    end
    if (strb.fixFreshStart && freshStored) mem[IW'(entryCount - 1'b1)] <= retireAddr;
    rdData <= mem[rdIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryCount  <= '0;
      overflow    <= 1'b0;
      retireCount <= '0;
      lastAddr    <= '0;
      expectAddr  <= '0;
      freshStored <= 1'b0;
    end else if (strb.clearAll) begin
      entryCount  <= '0;
      overflow    <= 1'b0;
      retireCount <= '0;
      freshStored <= 1'b0;
    end else begin
      if (strb.dropFresh && freshStored) entryCount <= entryCount - 1'b1;
      else                               entryCount <= entryCount + nFit;
      if (spill) overflow <= 1'b1;
      if (strb.countRetire) retireCount <= retireCount + 1'b1;
      if (strb.trackRetire) begin
        lastAddr   <= retireAddr;
        expectAddr <= strb.branchPair ? takenTarget : retireAddr + AW'(4);
      end
      if (strb.branchPair) freshStored <= (slotNum <= space);
    end
  end

  // R7: the count never passes the memory size
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    entryCount <= CW'(DEPTH));

  // R7: overflow holds until the next start
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !strb.clearAll) |=> overflow);

  // R8: the counter moves only on a counted retire
  a_r8_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countRetire && !strb.clearAll) |=> $stable(retireCount));

  // R1: start leaves an empty trace
  a_r1_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (entryCount == '0 && !overflow && retireCount == '0));

  // R5: patching a target does not change the count
  a_r5_fix_count: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fixFreshStart && !strb.branchPair) |=> $stable(entryCount));

endmodule

// File: rtl/run_trace_recorder.sv
module run_trace_recorder
  import rtr_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 32,
  parameter int CNTW  = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic            stopReq,
  input  logic            retireVld,
  input  logic [AW-1:0]   retireAddr,
  input  logic            takenVld,
  input  logic [AW-1:0]   takenTarget,
  input  logic [IW-1:0]   rdIdx,
  output logic [AW-1:0]   rdData,
  output logic [CW-1:0]   entryCount,
  output logic            overflow,
  output logic [CNTW-1:0] retireCount,
  output logic            recording
);

  rtrStrobes_t strb;
  logic        seqMatch;

  rtr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .stopReq   (stopReq),
    .retireVld (retireVld),
    .takenVld  (takenVld),
    .seqMatch  (seqMatch),
    .strb      (strb),
    .recording (recording)
  );

  rtr_datapath #(.DEPTH(DEPTH), .AW(AW), .CNTW(CNTW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .retireAddr  (retireAddr),
    .takenTarget (takenTarget),
    .rdIdx       (rdIdx),
    .seqMatch    (seqMatch),
    .rdData      (rdData),
    .entryCount  (entryCount),
    .overflow    (overflow),
    .retireCount (retireCount)
  );

endmodule

// File: tb/sim_run_trace_recorder.sv
module sim_run_trace_recorder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0, stopReq = 1'b0, retireVld = 1'b0, takenVld = 1'b0;
  logic [31:0] retireAddr = '0, takenTarget = '0;
  logic [5:0]  rdIdx = '0;
  logic [31:0] rdData;
  logic [6:0]  entryCount;
  logic        overflow;
  logic [31:0] retireCount;
  logic        recording;

  always #5 clk = ~clk;

  run_trace_recorder u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .retireVld(retireVld), .retireAddr(retireAddr), .takenVld(takenVld),
    .takenTarget(takenTarget), .rdIdx(rdIdx), .rdData(rdData),
    .entryCount(entryCount), .overflow(overflow), .retireCount(retireCount),
    .recording(recording)
  );

  int nChecks = 0, nErr = 0;
  bit finished = 1'b0;

  // Model built from the requirements
  logic [31:0] mEnt [64];
  int          mCount = 0;
  bit          mOvf = 0, mRec = 0, mRun = 0, mFresh = 0, mFreshSt = 0;
  logic [31:0] mLast = '0, mExp = '0;
  int unsigned mRet = 0;

  task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit mPush(logic [31:0] v);
    if (mCount < 64) begin
      mEnt[mCount] = v;
      mCount++;
      return 1'b1;
    end
    mOvf = 1'b1;
    return 1'b0;
  endfunction

  function automatic void modelStep(bit st, bit sp, bit vld, logic [31:0] a, bit tk, logic [31:0] tg);
    if (!mRec) begin
      if (st) begin
        mCount = 0; mOvf = 0; mRet = 0; mRec = 1; mRun = 0; mFresh = 0; mFreshSt = 0;
      end
    end else if (sp) begin
      if (mRun) begin
        if (mFresh) begin
          if (mFreshSt) mCount--;
        end else void'(mPush(mLast));
      end
      mRec = 0; mRun = 0; mFresh = 0;
    end else if (vld) begin
      mRet++;
      if (!mRun) void'(mPush(a));
      else if (a != mExp) begin
        if (mFresh) begin
          if (mFreshSt) mEnt[mCount-1] = a;
        end else begin
          void'(mPush(mLast));
          void'(mPush(a));
        end
      end
      if (tk) begin
        void'(mPush(a));
        mFreshSt = mPush(tg);
      end
      mRun = 1; mFresh = tk; mLast = a;
      mExp = tk ? tg : a + 32'd4;
    end
  endfunction

  task automatic cyc(bit st, bit sp, bit vld, logic [31:0] a, bit tk, logic [31:0] tg);
    @(negedge clk);
    startReq = st; stopReq = sp; retireVld = vld; retireAddr = a;
    takenVld = tk; takenTarget = tg;
    modelStep(st, sp, vld, a, tk, tg);
  endtask

  task automatic quiet();
    cyc(0, 0, 0, 32'h0, 0, 32'h0);
  endtask

  task automatic ret(logic [31:0] a, bit tk = 0, logic [31:0] tg = 32'h0);
    cyc(0, 0, 1, a, tk, tg);
  endtask

  // Compare everything visible at the ports against the model
  task automatic checkAll(string tag);
    logic [31:0] got [64];
    longint unsigned sum;
    quiet();
    chk("R7", {tag, " entryCount"}, entryCount, mCount);
    chk("R7", {tag, " overflow"}, overflow, mOvf);
    chk("R8", {tag, " retireCount"}, retireCount, mRet);
    chk("R6", {tag, " recording"}, recording, mRec);
    for (int i = 0; i < mCount; i++) begin
      @(negedge clk);
      rdIdx = 6'(i);
      @(negedge clk);
      got[i] = rdData;
      chk("R9", $sformatf("%s entry %0d", tag, i), rdData, mEnt[i]);
    end
    if (!mOvf && !mRec) begin
      sum = 0;
      for (int i = 0; i + 1 < mCount; i += 2) sum += (got[i+1] - got[i]) / 4 + 1;
      chk("R8", {tag, " run tally"}, sum, mRet);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    logic [31:0] pc, nx;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset entryCount", entryCount, 0);
    chk("R1", "reset overflow", overflow, 0);
    chk("R1", "reset retireCount", retireCount, 0);

    // Directed: sequential, taken, jump, target mismatch (R2 R3 R4 R5)
    cyc(1, 0, 0, 0, 0, 0);
    ret(32'h100); ret(32'h104); ret(32'h108);
    ret(32'h10C, 1, 32'h200);
    ret(32'h200); ret(32'h204);
    ret(32'h300);
    ret(32'h304, 1, 32'h400);
    ret(32'h500);
    ret(32'h504);
    cyc(0, 1, 1, 32'h508, 0, 0);  // R6 retire during stop ignored
    checkAll("R2 R3 R4 R5 directed");
    chk("R3", "directed entry total", mCount, 8);
    chk("R5", "patched start", mEnt[6], 32'h500);

    // R8 R10: strobes and stop while idle are ignored
    ret(32'h900); ret(32'h904);
    cyc(0, 1, 0, 0, 0, 0);
    checkAll("R10 idle");

    // R6: stop right after a taken branch withdraws the target
    cyc(1, 0, 0, 0, 0, 0);
    ret(32'h1000, 1, 32'h2000);
    cyc(0, 1, 0, 0, 0, 0);
    checkAll("R6 drop target");
    chk("R6", "entries after drop", mCount, 2);

    // R10: start while recording is ignored
    cyc(1, 0, 0, 0, 0, 0);
    ret(32'h3000);
    cyc(1, 0, 1, 32'h3004, 0, 0);
    ret(32'h3008);
    cyc(0, 1, 0, 0, 0, 0);
    checkAll("R10 restart");

    // R7: overflow with a burst of jumps
    cyc(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) ret(32'h10000 + 32'(i) * 32'h100);
    checkAll("R7 overflow");
    cyc(0, 1, 0, 0, 0, 0);
    checkAll("R7 overflow stopped");
    cyc(1, 0, 0, 0, 0, 0);
    checkAll("R1 restart clears");
    cyc(0, 1, 0, 0, 0, 0);

    // Random runs
    for (int r = 0; r < 40; r++) begin
      int n;
      n = 4 + int'($urandom % 24);
      pc = 32'h1000 + (($urandom % 32'h100000) << 2);
      cyc(1, 0, 0, 0, 0, 0);
      for (int i = 0; i < n; i++) begin
        int c;
        c = int'($urandom % 10);
        if (c < 2) pc = 32'h1000 + (($urandom % 32'h100000) << 2);
        if (c >= 8) begin
          nx = 32'h1000 + (($urandom % 32'h100000) << 2);
          ret(pc, 1, nx);
          pc = (($urandom % 5) == 0) ? nx + 32'h40 : nx;
        end else begin
          ret(pc);
          pc = pc + 32'd4;
        end
        if (($urandom % 6) == 0) quiet();
      end
      cyc(0, 1, 0, 0, 0, 0);
      checkAll($sformatf("R2 R3 R4 R5 R8 random %0d", r));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule